// File: doc/BRIEF.md
# Common-plus-Banked Memory Segmenter

This block sits between an 8-bit CPU with a 64K logical address space and a larger physical SRAM. The logical space is split in two at a programmable page boundary. Everything at or above the boundary is a common area that looks the same whatever bank is selected. Everything below it is switched among several banks by a bank-select register. The boundary is counted in 256-byte pages. Operating-system start-up code writes it once, and it then stays fixed until reset.

Both registers are written through two consecutive I/O ports. The bank-select port is at `IO_BASE` and the boundary port is at `IO_BASE+1`. The physical address is formed combinationally from the CPU address. A banked access prefixes the CPU address with the bank number. A common access prefixes it with zero, so common memory always lives in physical segment 0, which is the operating system's segment. With the default 3-bit bank field, eight segments are available: segment 0 for the system and seven for user banks.

The boundary logic is a two-state machine. In `CFG_OPEN`, the state after reset, a boundary write loads the boundary register and takes the transition `OPEN_TO_LOCKED`. In `CFG_LOCKED` every boundary write is dropped, and the machine stays there (`LOCKED_HOLD`) until reset returns it to `CFG_OPEN`. When no boundary write occurs in `CFG_OPEN`, the machine stays there (`OPEN_HOLD`).

Top module: `mem_segmenter`

## Requirements
- R1: After reset the bank register is 0, the boundary state is `CFG_OPEN`, and the whole 64K space is banked. Even address 0xFFFF maps to {bank, address} with `is_common` low.
- R2: An I/O write (`io_wr` high) to port `IO_BASE` loads the bank register from the low `BANK_W` bits of `io_wdata` and ignores the upper bits. The new bank applies to `phys_addr` from the clock edge that captures the write.
- R3: An access whose upper address byte is below the boundary produces `phys_addr` = {bank, cpu_addr}.
- R4: An access whose upper address byte is greater than or equal to the boundary produces `phys_addr` = {0, cpu_addr}, whatever bank is selected.
- R5: The first write to port `IO_BASE+1` after reset sets the boundary to `io_wdata` (page index of the first common page). A value of 0xC0 gives a 16K common area and 0xB0 gives a 20K common area.
- R6: Once a boundary has been written, every later boundary write is ignored until reset.
- R7: Port activity with `io_wr` low, or writes to ports other than the two decoded ones, changes neither register.
- R8: `is_common` is high exactly when the current access falls in the common area.
- R9: Reset returns the boundary to fully banked and re-opens it, so a new first write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | IO_W (8) | I/O port address |
| io_wdata | input | DATA_W (8) | I/O write data |
| cpu_addr | input | ADDR_W (16) | CPU logical address |
| phys_addr | output | BANK_W+ADDR_W (19) | Physical SRAM address |
| is_common | output | 1 | Current access is in the common area |

## Verification
A wrong bank register shows on the upper bits of `phys_addr` for the first banked access after the write cycle. A wrong boundary or lock state shows on `is_common`, and on the zeroed bank bits, for any address between the intended and the actual boundary. A lock that fails to hold is exposed by probing addresses between the first and the second written boundary directly after the second write. A lock that fails to release is exposed by the first boundary write after a second reset.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [0:0] {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_t;
endpackage

// File: rtl/seg_port_decode.sv
module seg_port_decode #(
    parameter int          IO_W    = 8,
    parameter logic [7:0]  IO_BASE = 8'h40
) (
    input  logic            io_wr,
    input  logic [IO_W-1:0] io_addr,
    output logic            bank_we,
    output logic            bnd_we
);
    localparam logic [IO_W-1:0] BANK_PORT = IO_W'(IO_BASE);
    localparam logic [IO_W-1:0] BND_PORT  = IO_W'(IO_BASE) + IO_W'(1);

    always_comb begin
        bank_we = io_wr && (io_addr == BANK_PORT);
        bnd_we  = io_wr && (io_addr == BND_PORT);
    end
endmodule

// File: rtl/seg_bank_reg.sv
module seg_bank_reg #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    generate
        if (DATA_W > BANK_W) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^wdata[DATA_W-1:BANK_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (bank_we)
            bank <= wdata[BANK_W-1:0];
    end
endmodule

// File: rtl/seg_cfg.sv
module seg_cfg
    import seg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnd_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W:0]   boundary,
    output logic              locked
);
    localparam logic [PAGE_W:0] ALL_BANKED = {1'b1, {PAGE_W{1'b0}}};

    cfg_state_t state, state_nx;
    logic       load_bnd;

    generate
        if (DATA_W > PAGE_W) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^wdata[DATA_W-1:PAGE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= CFG_OPEN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load_bnd = 1'b0;
        locked   = 1'b0;
        unique case (state)
            CFG_OPEN: begin
                if (bnd_we) begin
                    load_bnd = 1'b1;
                    state_nx = CFG_LOCKED;
                end
            end
            CFG_LOCKED: begin
                locked = 1'b1;
            end
            default: state_nx = CFG_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            boundary <= ALL_BANKED;
        else if (load_bnd)
            boundary <= {1'b0, wdata[PAGE_W-1:0]};
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3
) (
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [BANK_W-1:0]        bank,
    input  logic [ADDR_W-8:0]        boundary,
    output logic [BANK_W+ADDR_W-1:0] phys_addr,
    output logic                     is_common
);
    localparam int PAGE_W = ADDR_W - 8;

    logic [PAGE_W:0] page;

    always_comb begin
        page      = {1'b0, cpu_addr[ADDR_W-1 -: PAGE_W]};
        is_common = (page >= boundary);
        phys_addr = {(is_common ? {BANK_W{1'b0}} : bank), cpu_addr};
    end
endmodule

// File: rtl/mem_segmenter.sv
module mem_segmenter #(
    parameter int         ADDR_W  = 16,
    parameter int         BANK_W  = 3,
    parameter int         DATA_W  = 8,
    parameter int         IO_W    = 8,
    parameter logic [7:0] IO_BASE = 8'h40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     io_wr,
    input  logic [IO_W-1:0]          io_addr,
    input  logic [DATA_W-1:0]        io_wdata,
    input  logic [ADDR_W-1:0]        cpu_addr,
    output logic [BANK_W+ADDR_W-1:0] phys_addr,
    output logic                     is_common
);
    localparam int PAGE_W = ADDR_W - 8;

    logic              bank_we;
    logic              bnd_we;
    logic [BANK_W-1:0] cur_bank;
    logic [PAGE_W:0]   boundary;
    logic              cfg_locked;

    seg_port_decode #(.IO_W(IO_W), .IO_BASE(IO_BASE)) u_dec (
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .bank_we (bank_we),
        .bnd_we  (bnd_we)
    );

    seg_bank_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_we (bank_we),
        .wdata   (io_wdata),
        .bank    (cur_bank)
    );

    seg_cfg #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bnd_we   (bnd_we),
        .wdata    (io_wdata),
        .boundary (boundary),
        .locked   (cfg_locked)
    );

    seg_xlate #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_xl (
        .cpu_addr  (cpu_addr),
        .bank      (cur_bank),
        .boundary  (boundary),
        .phys_addr (phys_addr),
        .is_common (is_common)
    );
endmodule

// File: rtl/mem_segmenter_chk.sv
module mem_segmenter_chk #(
    parameter int         ADDR_W  = 16,
    parameter int         BANK_W  = 3,
    parameter int         DATA_W  = 8,
    parameter int         IO_W    = 8,
    parameter logic [7:0] IO_BASE = 8'h40
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     io_wr,
    input logic [IO_W-1:0]          io_addr,
    input logic [DATA_W-1:0]        io_wdata,
    input logic [ADDR_W-1:0]        cpu_addr,
    input logic [BANK_W+ADDR_W-1:0] phys_addr,
    input logic                     is_common,
    input logic [BANK_W-1:0]        bank,
    input logic [ADDR_W-8:0]        boundary,
    input logic                     locked
);
    localparam logic [IO_W-1:0] BANK_PORT = IO_W'(IO_BASE);
    localparam logic [IO_W-1:0] BND_PORT  = IO_W'(IO_BASE) + IO_W'(1);

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == BANK_PORT) |=> (bank == $past(io_wdata[BANK_W-1:0]))); // R2

    AST_BANKED_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        !is_common |-> (phys_addr[BANK_W+ADDR_W-1:ADDR_W] == bank)); // R3

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[ADDR_W-1:0] == cpu_addr); // R3

    AST_COMMON_SEG0: assert property (@(posedge clk) disable iff (!rst_n)
        is_common |-> (phys_addr[BANK_W+ADDR_W-1:ADDR_W] == '0)); // R4

    AST_FIRST_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && io_wr && io_addr == BND_PORT) |=> locked); // R5

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R6

    AST_LOCKED_BND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(boundary)); // R6

    AST_OPEN_ALL_BANKED: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !is_common); // R1
endmodule

bind mem_segmenter mem_segmenter_chk #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .IO_W(IO_W), .IO_BASE(IO_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .cpu_addr  (cpu_addr),
    .phys_addr (phys_addr),
    .is_common (is_common),
    .bank      (cur_bank),
    .boundary  (boundary),
    .locked    (cfg_locked)
);

// File: tb/mem_segmenter_test.sv
`timescale 1ns/1ps
module mem_segmenter_test;
    localparam int ADDR_W = 16;
    localparam int BANK_W = 3;
    localparam int PA_W   = BANK_W + ADDR_W;
    localparam logic [7:0] BASE = 8'h40;

    typedef struct {
        logic [PA_W-1:0] phys;
        logic            com;
        string           tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              io_wr = 1'b0;
    logic [7:0]        io_addr = '0;
    logic [7:0]        io_wdata = '0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [PA_W-1:0]   phys_addr;
    logic              is_common;

    int n_checks = 0;
    int n_fail   = 0;
    exp_t q[$];

    logic [BANK_W-1:0] m_bank;
    logic [8:0]        m_bnd;
    logic              m_locked;

    always #2.5 clk = ~clk;

    mem_segmenter #(.IO_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .cpu_addr(cpu_addr),
        .phys_addr(phys_addr), .is_common(is_common)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_bank = '0; m_bnd = 9'h100; m_locked = 1'b0;
    endtask

    task automatic io_cycle(input logic wr, input logic [7:0] port, input logic [7:0] d);
        @(negedge clk);
        io_wr = wr; io_addr = port; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (wr && port == BASE) m_bank = d[BANK_W-1:0];
        if (wr && port == BASE + 8'd1 && !m_locked) begin
            m_bnd = {1'b0, d}; m_locked = 1'b1;
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        cpu_addr = a;
        e.com  = ({1'b0, a[15:8]} >= m_bnd);
        e.phys = {(e.com ? {BANK_W{1'b0}} : m_bank), a};
        e.tag  = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_checks++;
                if (phys_addr !== e.phys) begin
                    n_fail++;
                    $display("FAIL %s phys_addr actual=%h expected=%h", e.tag, phys_addr, e.phys);
                end
                n_checks++;
                if (is_common !== e.com) begin
                    n_fail++;
                    $display("FAIL %s is_common actual=%b expected=%b", e.tag, is_common, e.com);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : driver
        do_reset();
        // R1: reset state, bank 0 and all banked
        access(16'hFF00, "R1 reset bank0");
        access(16'h0000, "R1 reset low");
        io_cycle(1'b1, BASE, 8'h05);
        access(16'hFFFF, "R1 top still banked");
        // R2: low bits only (0x0D -> 5, 0xFA -> 2)
        io_cycle(1'b1, BASE, 8'h0D);
        access(16'h1234, "R2 bank 0x0D");
        io_cycle(1'b1, BASE, 8'hFA);
        access(16'h8000, "R2 bank 0xFA");
        // R7: no strobe, wrong ports
        io_cycle(1'b0, BASE, 8'h07);
        access(16'h4000, "R7 no strobe bank");
        io_cycle(1'b1, BASE + 8'd2, 8'h06);
        access(16'h4001, "R7 other port");
        io_cycle(1'b0, BASE + 8'd1, 8'h10);
        access(16'h2000, "R7 no strobe boundary");
        // R5: 16K common
        io_cycle(1'b1, BASE + 8'd1, 8'hC0);
        access(16'hBFFF, "R5 R3 below 16K common");
        access(16'hC000, "R5 R8 first common byte");
        io_cycle(1'b1, BASE, 8'h07);
        access(16'hFFFF, "R4 common ignores bank7");
        access(16'h0100, "R3 banked bank7");
        // R6: second write ignored
        io_cycle(1'b1, BASE + 8'd1, 8'hB0);
        access(16'hB000, "R6 still banked");
        access(16'hBFFF, "R6 below old boundary");
        io_cycle(1'b1, BASE + 8'd1, 8'h00);
        access(16'h0000, "R6 zero ignored");
        // R9: reset re-opens, 20K common
        do_reset();
        access(16'hF000, "R9 R1 after reset");
        io_cycle(1'b1, BASE, 8'h03);
        io_cycle(1'b1, BASE + 8'd1, 8'hB0);
        access(16'hAFFF, "R9 R3 below 20K common");
        access(16'hB000, "R9 R4 20K common");
        access(16'hB0FF, "R8 common page");
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule